// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block is a small, fully associative store of recent translations from virtual page numbers to physical frame numbers. Each entry is labelled with the identifier of the process that owns it. A context switch therefore needs no flush: an entry answers only when both its page number and its process label match the lookup. The same physical frame can sit in entries for several processes, each with its own rights. One process might have execute-only rights to a shared library page while another has read-only rights to it.

A lookup presents a page number, the current process label and an access kind. One cycle later the block reports one of three results. A hit returns the frame and the rights. A miss tells the trap handler to walk the page tables. A protection fault means a matching entry exists but forbids the access; copy-on-write relies on this for stores to read-only pages. Software loads translations through a fill port after a miss. It removes one page's translation through a shootdown port when the page is swapped out, and it can flush the whole table in one cycle.

Top module: `pid_tlb`

## Requirements
- R1: After reset, every entry is invalid, all result outputs are zero, and the first lookup reports a miss.
- R2: A lookup whose page number and process label both match a valid entry that permits the access reports a hit on the next clock edge. It returns that entry's frame and rights.
- R3: An entry whose page number matches but whose process label differs does not answer. The lookup reports a miss.
- R4: Rights are three bits: bit 0 allows loads (access code 0), bit 1 allows stores (code 1) and bit 2 allows instruction fetch (code 2). Code 3 is never allowed. A matching entry that forbids the access gives a fault, which also returns its frame and rights.
- R5: At most one of hit, miss and fault is high in any cycle. Exactly one is high in the cycle after a lookup request and none in the cycle after a cycle without one. Frame and rights read zero on a miss and when no lookup was made.
- R6: A fill with no existing match writes the lowest-numbered invalid entry.
- R7: A fill whose page number and process label are already present overwrites that entry, so no duplicate ever exists.
- R8: A fill into a full table with no match replaces the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, only on such a replacement.
- R9: A shootdown invalidates the entry matching its page number and process label. Entries for the same page under other process labels stay.
- R10: A flush invalidates every entry in one cycle.
- R11: A lookup in the same cycle as a fill, shootdown or flush sees the table as it was before that update.
- R12: If several updates are requested in one cycle, flush takes precedence over shootdown and shootdown over fill. The lower-priority requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 8 | Current process label |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| res_hit | output | 1 | Registered hit |
| res_miss | output | 1 | Registered miss (trap for refill) |
| res_fault | output | 1 | Registered protection fault |
| res_pfn | output | 20 | Frame of the matching entry |
| res_perm | output | 3 | Rights of the matching entry |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Page number to write |
| fill_pid | input | 8 | Process label to write |
| fill_pfn | input | 20 | Frame to write |
| fill_perm | input | 3 | Rights to write |
| shoot_en | input | 1 | Invalidate one translation |
| shoot_vpn | input | 20 | Page number to invalidate |
| shoot_pid | input | 8 | Process label to invalidate |
| flush_en | input | 1 | Invalidate all entries |

## Verification
The bench goes after a shared page held by two processes with different rights. A design that matched only the page number would return the wrong process's rights, or hit where it should miss. It issues a lookup in the same cycle as the fill that would satisfy it. A design that forwarded the new entry would report a hit where a miss is required. It refills an existing translation with new rights and then fills a full table twice. If duplicates were kept, or the round-robin pointer advanced on the wrong kind of fill, a later lookup would find an entry that should be gone or lose one that should remain. It also sends flush, shootdown and fill together. A wrong priority would leave a stale entry visible after the flush.

// File: rtl/tlb_pkg.sv
// Shared definitions for the process-tagged TLB.
// Assumes rights are three bits: load, store, fetch at bit positions 0, 1, 2.
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int RIGHT_LD = 0;
    localparam int RIGHT_ST = 1;
    localparam int RIGHT_EX = 2;
    localparam int RIGHTS_W = 3;

    // Decide whether a rights field allows an access kind.
    function automatic logic access_allowed(input logic [RIGHTS_W-1:0] rights,
                                            input logic [1:0] acc);
        case (acc)
            ACC_LOAD:  return rights[RIGHT_LD];
            ACC_STORE: return rights[RIGHT_ST];
            ACC_FETCH: return rights[RIGHT_EX];
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_tag_match.sv
// Parallel tag comparator: one match line per entry.
// An entry matches when it is valid and both page number and process label agree.
// Purely combinational; the caller decides what a match means.
module tlb_tag_match #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PID_W = 8
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] tab_vpn,
    input  logic [N-1:0][PID_W-1:0] tab_pid,
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [PID_W-1:0]        key_pid,
    output logic [N-1:0]            match
);

    // One comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tab_vpn[g] == key_vpn) && (tab_pid[g] == key_pid);
    end

endmodule

// File: rtl/tlb_victim.sv
// Replacement selector: reports the lowest invalid entry and keeps a
// round-robin pointer that advances only when the caller uses it.
// Assumes N is at least 2.
module tlb_victim #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic             take_rr,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx,
    output logic [IDX_W-1:0] rr_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    // Priority search for the lowest-numbered invalid entry.
    always_comb begin
        any_free = ~&valid;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    // Round-robin pointer, advanced only on a replacement of a live entry.
    always_ff @(posedge clk) begin
        if (!rst_n)       rr_idx <= '0;
        else if (take_rr) rr_idx <= (rr_idx == LAST) ? '0 : rr_idx + 1'b1;
    end

endmodule

// File: rtl/pid_tlb.sv
// Process-tagged fully associative TLB.
// A lookup is matched combinationally against the current table and its
// result is registered, so updates in the same cycle are not visible to it.
// Update priority: flush, then shootdown, then fill. Fills never create
// duplicates, so at most one entry matches any page/process pair.
module pid_tlb #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int PID_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [PID_W-1:0] lk_pid,
    input  logic [1:0]       lk_acc,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_fault,
    output logic [PFN_W-1:0] res_pfn,
    output logic [2:0]       res_perm,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [2:0]       fill_perm,
    input  logic             shoot_en,
    input  logic [VPN_W-1:0] shoot_vpn,
    input  logic [PID_W-1:0] shoot_pid,
    input  logic             flush_en
);
    import tlb_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]                valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0]     vpn_q;
    logic [ENTRIES-1:0][PID_W-1:0]     pid_q;
    logic [ENTRIES-1:0][PFN_W-1:0]     pfn_q;
    logic [ENTRIES-1:0][RIGHTS_W-1:0]  perm_q;

    logic [ENTRIES-1:0] lk_match, fill_match, shoot_match;
    logic               lk_any, lk_ok, fill_dup, any_free, do_fill, do_shoot, take_rr;
    logic [PFN_W-1:0]   sel_pfn;
    logic [RIGHTS_W-1:0] sel_perm;
    logic [IDX_W-1:0]   dup_idx, free_idx, rr_idx, wr_idx;

    tlb_tag_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_match (
        .valid(valid_q), .tab_vpn(vpn_q), .tab_pid(pid_q),
        .key_vpn(lk_vpn), .key_pid(lk_pid), .match(lk_match));

    tlb_tag_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_fill_match (
        .valid(valid_q), .tab_vpn(vpn_q), .tab_pid(pid_q),
        .key_vpn(fill_vpn), .key_pid(fill_pid), .match(fill_match));

    tlb_tag_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_shoot_match (
        .valid(valid_q), .tab_vpn(vpn_q), .tab_pid(pid_q),
        .key_vpn(shoot_vpn), .key_pid(shoot_pid), .match(shoot_match));

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid_q), .take_rr(take_rr),
        .any_free(any_free), .free_idx(free_idx), .rr_idx(rr_idx));

    // Merge the (at most one) matching lookup entry into frame and rights.
    always_comb begin
        sel_pfn  = '0;
        sel_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                sel_pfn  = sel_pfn  | pfn_q[i];
                sel_perm = sel_perm | perm_q[i];
            end
        end
        lk_any = |lk_match;
        lk_ok  = access_allowed(sel_perm, lk_acc);
    end

    // Choose the fill slot: existing match, else lowest free, else round-robin.
    always_comb begin
        dup_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_match[i]) dup_idx = IDX_W'(i);
        end
        fill_dup = |fill_match;
        do_shoot = shoot_en && !flush_en;
        do_fill  = fill_en && !flush_en && !shoot_en;
        take_rr  = do_fill && !fill_dup && !any_free;
        if (fill_dup)      wr_idx = dup_idx;
        else if (any_free) wr_idx = free_idx;
        else               wr_idx = rr_idx;
    end

    // Register the lookup outcome from the pre-update table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_fault <= 1'b0;
            res_pfn   <= '0;
            res_perm  <= '0;
        end else begin
            res_hit   <= lk_valid && lk_any && lk_ok;
            res_fault <= lk_valid && lk_any && !lk_ok;
            res_miss  <= lk_valid && !lk_any;
            res_pfn   <= (lk_valid && lk_any) ? sel_pfn  : '0;
            res_perm  <= (lk_valid && lk_any) ? sel_perm : '0;
        end
    end

    // Apply at most one table update per cycle by priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            vpn_q   <= '0;
            pid_q   <= '0;
            pfn_q   <= '0;
            perm_q  <= '0;
        end else if (flush_en) begin
            valid_q <= '0;
        end else if (do_shoot) begin
            valid_q <= valid_q & ~shoot_match;
        end else if (do_fill) begin
            valid_q[wr_idx] <= 1'b1;
            vpn_q[wr_idx]   <= fill_vpn;
            pid_q[wr_idx]   <= fill_pid;
            pfn_q[wr_idx]   <= fill_pfn;
            perm_q[wr_idx]  <= fill_perm;
        end
    end

endmodule

// File: rtl/pid_tlb_chk.sv
// Property checker for pid_tlb, attached by bind. Observes ports and the
// valid vector only; drives nothing.
module pid_tlb_chk #(
    parameter int ENTRIES = 16,
    parameter int PFN_W   = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               res_hit,
    input logic               res_miss,
    input logic               res_fault,
    input logic [PFN_W-1:0]   res_pfn,
    input logic [2:0]         res_perm,
    input logic               fill_en,
    input logic               shoot_en,
    input logic               flush_en,
    input logic [ENTRIES-1:0] valid_q
);

    // R5
    excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_hit, res_miss, res_fault}));

    // R5
    result_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_hit || res_miss || res_fault));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(res_hit || res_miss || res_fault));

    // R5
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_pfn == '0 && res_perm == '0));

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (valid_q == '0));

    // R6
    fill_occupies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !shoot_en && !flush_en) |=> (valid_q != '0));

    // R12
    no_silent_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shoot_en && !flush_en) |=> ($countones(valid_q) >= $past($countones(valid_q))));

endmodule

bind pid_tlb pid_tlb_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
    .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
    .res_pfn(res_pfn), .res_perm(res_perm),
    .fill_en(fill_en), .shoot_en(shoot_en), .flush_en(flush_en),
    .valid_q(valid_q));

// File: tb/pid_tlb_bench.sv
`timescale 1ns/1ps
module pid_tlb_bench;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_pid = '0;
    logic [1:0]  lk_acc = '0;
    logic        res_hit, res_miss, res_fault;
    logic [19:0] res_pfn;
    logic [2:0]  res_perm;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_pid = '0;
    logic [19:0] fill_pfn = '0;
    logic [2:0]  fill_perm = '0;
    logic        shoot_en = 1'b0;
    logic [19:0] shoot_vpn = '0;
    logic [7:0]  shoot_pid = '0;
    logic        flush_en = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference table kept by the bench.
    bit          m_v   [N];
    logic [19:0] m_vpn [N];
    logic [7:0]  m_pid [N];
    logic [19:0] m_pfn [N];
    logic [2:0]  m_perm[N];
    int          m_rr;

    always #10 clk = ~clk;

    pid_tlb u_pid_tlb (.*);

    // Expected registered result {hit, miss, fault, pfn, perm}.
    function automatic logic [25:0] expect_lookup();
        logic [25:0] r;
        r = '0;
        if (!lk_valid) return r;
        r[24] = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_vpn[i] == lk_vpn && m_pid[i] == lk_pid) begin
                bit ok;
                case (lk_acc)
                    2'd0: ok = m_perm[i][0];
                    2'd1: ok = m_perm[i][1];
                    2'd2: ok = m_perm[i][2];
                    default: ok = 1'b0;
                endcase
                r = {ok, 1'b0, !ok, m_pfn[i], m_perm[i]};
            end
        end
        return r;
    endfunction

    // Apply the update the design should perform this cycle.
    task automatic model_update();
        if (flush_en) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else if (shoot_en) begin
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == shoot_vpn && m_pid[i] == shoot_pid) m_v[i] = 1'b0;
        end else if (fill_en) begin
            int slot = -1;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == fill_vpn && m_pid[i] == fill_pid) slot = i;
            if (slot < 0)
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[slot] = 1'b1; m_vpn[slot] = fill_vpn; m_pid[slot] = fill_pid;
            m_pfn[slot] = fill_pfn; m_perm[slot] = fill_perm;
        end
    endtask

    // One clock: inputs already set at a falling edge; compare at the next one.
    task automatic cycle(input string tag);
        logic [25:0] exp_r, act_r;
        exp_r = expect_lookup();
        model_update();
        @(negedge clk);
        act_r = {res_hit, res_miss, res_fault, res_pfn, res_perm};
        checks++;
        if (act_r !== exp_r) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act_r, exp_r);
        end
        lk_valid = 1'b0; fill_en = 1'b0; shoot_en = 1'b0; flush_en = 1'b0;
    endtask

    task automatic look(input logic [19:0] v, input logic [7:0] p, input logic [1:0] a);
        lk_valid = 1'b1; lk_vpn = v; lk_pid = p; lk_acc = a;
    endtask

    task automatic fill(input logic [19:0] v, input logic [7:0] p,
                        input logic [19:0] f, input logic [2:0] r);
        fill_en = 1'b1; fill_vpn = v; fill_pid = p; fill_pfn = f; fill_perm = r;
    endtask

    task automatic shoot(input logic [19:0] v, input logic [7:0] p);
        shoot_en = 1'b1; shoot_vpn = v; shoot_pid = p;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(20ns * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd2016);
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_vpn[i] = '0; m_pid[i] = '0; m_pfn[i] = '0; m_perm[i] = '0;
        end
        m_rr = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle outputs after reset, first lookup misses.
        cycle("R1 idle after reset");
        look(20'h5, 8'd1, 2'd0); cycle("R1 first lookup miss");

        // R2/R3/R4: read-only entry for process 1.
        fill(20'h5, 8'd1, 20'hABC, 3'b001); cycle("R6 fill");
        look(20'h5, 8'd1, 2'd0); cycle("R2 load hit");
        look(20'h5, 8'd1, 2'd1); cycle("R4 store to read-only faults");
        look(20'h5, 8'd2, 2'd0); cycle("R3 other process misses");
        look(20'h5, 8'd1, 2'd3); cycle("R4 reserved code faults");

        // R4: shared frame, execute-only for process 2.
        fill(20'h5, 8'd2, 20'hABC, 3'b100); cycle("R6 shared fill");
        look(20'h5, 8'd2, 2'd2); cycle("R4 fetch hit exec-only");
        look(20'h5, 8'd2, 2'd0); cycle("R4 load on exec-only faults");
        look(20'h5, 8'd1, 2'd0); cycle("R3 process 1 rights kept");

        // R11: lookup alongside the fill that would satisfy it.
        look(20'h7, 8'd1, 2'd0); fill(20'h7, 8'd1, 20'h777, 3'b011); cycle("R11 same-cycle fill miss");
        look(20'h7, 8'd1, 2'd1); cycle("R11 hit after fill");

        // R7: refill existing pair with new frame and rights.
        fill(20'h5, 8'd1, 20'h111, 3'b011); cycle("R7 duplicate fill");
        look(20'h5, 8'd1, 2'd1); cycle("R7 store hits new rights");

        // R9: shootdown of one process only.
        look(20'h5, 8'd1, 2'd0); shoot(20'h5, 8'd1); cycle("R11 same-cycle shoot sees old");
        look(20'h5, 8'd1, 2'd0); cycle("R9 shot entry misses");
        look(20'h5, 8'd2, 2'd2); cycle("R9 other process survives");

        // R12: flush beats fill; R10 flush clears all.
        flush_en = 1'b1; fill(20'h9, 8'd1, 20'h999, 3'b111); cycle("R12 flush with fill");
        look(20'h9, 8'd1, 2'd0); cycle("R12 dropped fill absent");
        look(20'h7, 8'd1, 2'd0); cycle("R10 flushed entry misses");

        // R12: shootdown beats fill.
        shoot(20'h1, 8'd1); fill(20'hA, 8'd1, 20'hAAA, 3'b111); cycle("R12 shoot with fill");
        look(20'hA, 8'd1, 2'd0); cycle("R12 fill dropped under shoot");

        // R8: fill the table, then replace round-robin.
        for (int i = 0; i < N; i++) begin
            fill(20'h100 + 20'(i), 8'd3, 20'h500 + 20'(i), 3'b001); cycle("R6 table fill");
        end
        fill(20'h200, 8'd3, 20'h600, 3'b001); cycle("R8 first replacement");
        look(20'h100, 8'd3, 2'd0); cycle("R8 entry 0 evicted");
        look(20'h101, 8'd3, 2'd0); cycle("R8 entry 1 kept");
        fill(20'h201, 8'd3, 20'h601, 3'b001); cycle("R8 second replacement");
        look(20'h101, 8'd3, 2'd0); cycle("R8 entry 1 evicted");
        look(20'h102, 8'd3, 2'd0); cycle("R8 entry 2 kept");
        fill(20'h102, 8'd3, 20'h602, 3'b011); cycle("R7 dup in full table");
        look(20'h103, 8'd3, 2'd0); cycle("R8 pointer not moved by dup");

        // Random mix against the reference table.
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if ($urandom_range(0, 3) != 0)
                look(20'($urandom_range(0, 23)), 8'($urandom_range(0, 2)), 2'($urandom_range(0, 3)));
            if (r < 30)
                fill(20'($urandom_range(0, 23)), 8'($urandom_range(0, 2)),
                     20'($urandom), 3'($urandom_range(0, 7)));
            if (r >= 30 && r < 38)
                shoot(20'($urandom_range(0, 23)), 8'($urandom_range(0, 2)));
            if (r == 99) flush_en = 1'b1;
            cycle("R2 R3 R4 R11 R12 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule